// File: doc/BRIEF.md
# Banked Cache Array Conflict Checker

This block decides, in the cycle a request is raised, whether a cache controller may use its tag array and its data array. Each array is split into banks. A bank that has just served an access stays occupied for a fixed number of cycles. The block keeps one busy timer per bank and picks the bank from the low bits of the cache set index. It answers every request with a grant bit in the same cycle. Refusals are counted in two saturating counters, one for each array.

Each array has a small number of request lanes that are evaluated in one cycle. Lane 0 has the highest priority. All lanes raised in one cycle belong to a single controller transition. If any lane on either array is refused, the whole transition is told to stall. A lane that repeats the set index of a lane already granted in the same cycle is treated as a duplicate and is granted as well. A global enable input can switch the whole check off. Tag and data arrays have their own bank count and their own occupancy time.

Top module: `bank_gate`

## Requirements
- R1: A request goes to bank (set index mod bank count), which is the low bits of the set index because bank counts are powers of two. With one bank, every request goes to bank 0.
- R2: A grant in cycle t, on an array with occupancy L ≥ 1, marks its bank busy. Requests to that bank in cycles t+1 through t+L−1 are refused, and a request in cycle t+L is granted.
- R3: On an array with occupancy 0, every raised lane is granted and no bank ever becomes busy.
- R4: Within one cycle, lanes are taken in order from lane 0 upward. A lane that hits a bank already claimed by an earlier lane in the same cycle is granted when its set index equals the claiming set index, and the timer is not reloaded. It is refused when the set index differs.
- R5: A request to a bank still busy from an earlier cycle is refused, even when it carries the set index that made the bank busy.
- R6: While the enable input is low, every raised lane is granted and no bank is marked busy. Timers that are already running keep counting down.
- R7: Each array's stall counter adds the number of lanes refused on that array in a cycle. The new value shows on the output after the next rising clock edge.
- R8: A stall counter stops at its all-ones value and holds there.
- R9: xact_stall is high in a cycle exactly when at least one raised lane on either array is refused in that cycle.
- R10: The tag array and the data array are checked independently and in parallel. Requests on one array never change the grants of the other.
- R11: A synchronous reset clears both counters and every bank timer. A lane that is not raised never has its grant bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_en | input | 1 | Conflict checking enabled when high |
| tag_req | input | LANES | Tag array request, one bit per lane |
| tag_set | input | LANES×SET_W | Set index per tag lane |
| tag_grant | output | LANES | Same-cycle grant per tag lane |
| data_req | input | LANES | Data array request, one bit per lane |
| data_set | input | LANES×SET_W | Set index per data lane |
| data_grant | output | LANES | Same-cycle grant per data lane |
| xact_stall | output | 1 | Some raised lane was refused this cycle |
| tag_stall_cnt | output | CNT_W | Saturating count of refused tag lanes |
| data_stall_cnt | output | CNT_W | Saturating count of refused data lanes |

## Verification
The assertions assume that every bank count is a power of two and that the set index is at least as wide as the bank select. Under that assumption, set index mod bank count and the low-bit select pick the same bank. They also assume that requests and set indices hold steady through each cycle, since grants are combinational. The stimulus uses bank counts of 1, 2 and 4 and drives every input only at the falling clock edge. Set indices are kept inside SET_W. Conflicts are created on purpose, both across cycles and between lanes inside one cycle, while the enable input is toggled.

// File: rtl/bag_pkg.sv
package bag_pkg;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bag_sat_counter.sv
module bag_sat_counter
    import bag_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned INC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     cnt
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + (W+1)'(inc);
        if (sum[W]) begin
            st_d.cnt = '1;
        end else begin
            st_d.cnt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R8: once at the top value the counter stays there
    a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt == '1) |=> (cnt == '1));

    // R7: the counter never moves backwards outside reset
    a_r7_monotone: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt >= $past(cnt)));

    // R7: below saturation each step equals the refusal count
    a_r7_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt == '1) || ((cnt - $past(cnt)) == W'($past(inc)))));

endmodule

// File: rtl/bag_bank_array.sv
module bag_bank_array
    import bag_pkg::*;
#(
    parameter int unsigned BANKS   = 1,
    parameter int unsigned LATENCY = 1,
    parameter int unsigned SET_W   = 8,
    parameter int unsigned LANES   = 2,
    localparam int unsigned RW     = idx_bits(LANES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stall_en,
    input  logic [LANES-1:0]            req,
    input  logic [LANES-1:0][SET_W-1:0] set_idx,
    output logic [LANES-1:0]            grant,
    output logic [RW-1:0]               refused
);

    localparam int unsigned BB = idx_bits(BANKS);

    logic [LANES-1:0][BB-1:0] lane_bank;

    for (genvar g = 0; g < LANES; g++) begin : g_lane_bank
        if (BANKS == 1) begin : g_single
            assign lane_bank[g] = '0;
        end else begin : g_multi
            assign lane_bank[g] = set_idx[g][BB-1:0];
        end
    end

    if (LATENCY == 0) begin : g_no_timer
        assign grant   = req;
        assign refused = '0;
    end else begin : g_timer
        localparam int unsigned TW = idx_bits(LATENCY);

        typedef struct packed {
            logic [BANKS-1:0][TW-1:0] timer;
        } bank_state_t;

        bank_state_t st_d, st_q;
        logic [LANES-1:0] grant_c;
        logic [RW-1:0]    refused_c;

        always_comb begin : p_eval
            logic [BANKS-1:0]            claimed;
            logic [BANKS-1:0][SET_W-1:0] claim_set;
            st_d      = st_q;
            grant_c   = '0;
            refused_c = '0;
            claimed   = '0;
            claim_set = '0;
            for (int b = 0; b < int'(BANKS); b++) begin
                if (st_q.timer[b] != '0) begin
                    st_d.timer[b] = st_q.timer[b] - TW'(1);
                end
            end
            for (int i = 0; i < int'(LANES); i++) begin
                if (req[i]) begin
                    if (!stall_en) begin
                        grant_c[i] = 1'b1;
                    end else if (st_q.timer[lane_bank[i]] != '0) begin
                        refused_c = refused_c + RW'(1);
                    end else if (claimed[lane_bank[i]] &&
                                 (claim_set[lane_bank[i]] != set_idx[i])) begin
                        refused_c = refused_c + RW'(1);
                    end else begin
                        grant_c[i] = 1'b1;
                        if (!claimed[lane_bank[i]]) begin
                            claimed[lane_bank[i]]    = 1'b1;
                            claim_set[lane_bank[i]]  = set_idx[i];
                            st_d.timer[lane_bank[i]] = TW'(LATENCY - 1);
                        end
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign grant   = grant_c;
        assign refused = refused_c;

        logic over_bound;
        always_comb begin
            over_bound = 1'b0;
            for (int b = 0; b < int'(BANKS); b++) begin
                if (32'(st_q.timer[b]) > (LATENCY - 1)) begin
                    over_bound = 1'b1;
                end
            end
        end

        // R2: no bank is ever held longer than the occupancy time
        a_r2_timer_bound: assert property (@(posedge clk) disable iff (rst)
            !over_bound);

        // R2: lane 0 always claims its bank when granted with checking on
        a_r2_load: assert property (@(posedge clk) disable iff (rst)
            (stall_en && req[0] && grant[0]) |=>
            (st_q.timer[$past(lane_bank[0])] == TW'(LATENCY - 1)));

        // R5: a bank busy from an earlier cycle refuses lane 0
        a_r5_busy_refuse: assert property (@(posedge clk) disable iff (rst)
            (stall_en && req[0] && (st_q.timer[lane_bank[0]] != '0)) |-> !grant[0]);

        // R6: with checking off every raised lane is granted
        a_r6_bypass_grant: assert property (@(posedge clk) disable iff (rst)
            !stall_en |-> (grant == req));

        // R6: with checking off an idle array stays idle
        a_r6_no_mark: assert property (@(posedge clk) disable iff (rst)
            (!stall_en && (st_q == '0)) |=> (st_q == '0));
    end

    // R11: no grant without a request
    a_r11_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0));

endmodule

// File: rtl/bank_gate.sv
module bank_gate
    import bag_pkg::*;
#(
    parameter int unsigned SET_W      = 8,
    parameter int unsigned LANES      = 2,
    parameter int unsigned TAG_BANKS  = 1,
    parameter int unsigned TAG_LAT    = 1,
    parameter int unsigned DATA_BANKS = 1,
    parameter int unsigned DATA_LAT   = 1,
    parameter int unsigned CNT_W      = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stall_en,
    input  logic [LANES-1:0]            tag_req,
    input  logic [LANES-1:0][SET_W-1:0] tag_set,
    output logic [LANES-1:0]            tag_grant,
    input  logic [LANES-1:0]            data_req,
    input  logic [LANES-1:0][SET_W-1:0] data_set,
    output logic [LANES-1:0]            data_grant,
    output logic                        xact_stall,
    output logic [CNT_W-1:0]            tag_stall_cnt,
    output logic [CNT_W-1:0]            data_stall_cnt
);

    localparam int unsigned RW = idx_bits(LANES + 1);

    logic [RW-1:0] tag_refused;
    logic [RW-1:0] data_refused;

    bag_bank_array #(
        .BANKS   (TAG_BANKS),
        .LATENCY (TAG_LAT),
        .SET_W   (SET_W),
        .LANES   (LANES)
    ) u_tag (
        .clk      (clk),
        .rst      (rst),
        .stall_en (stall_en),
        .req      (tag_req),
        .set_idx  (tag_set),
        .grant    (tag_grant),
        .refused  (tag_refused)
    );

    bag_bank_array #(
        .BANKS   (DATA_BANKS),
        .LATENCY (DATA_LAT),
        .SET_W   (SET_W),
        .LANES   (LANES)
    ) u_data (
        .clk      (clk),
        .rst      (rst),
        .stall_en (stall_en),
        .req      (data_req),
        .set_idx  (data_set),
        .grant    (data_grant),
        .refused  (data_refused)
    );

    bag_sat_counter #(
        .W     (CNT_W),
        .INC_W (RW)
    ) u_tag_cnt (
        .clk (clk),
        .rst (rst),
        .inc (tag_refused),
        .cnt (tag_stall_cnt)
    );

    bag_sat_counter #(
        .W     (CNT_W),
        .INC_W (RW)
    ) u_data_cnt (
        .clk (clk),
        .rst (rst),
        .inc (data_refused),
        .cnt (data_stall_cnt)
    );

    assign xact_stall = (tag_refused != '0) || (data_refused != '0);

    // R9: the transition stall matches the refused lanes seen at the ports
    a_r9_stall_match: assert property (@(posedge clk) disable iff (rst)
        xact_stall == (((tag_req & ~tag_grant) | (data_req & ~data_grant)) != '0));

endmodule

// File: tb/bank_gate_test.sv
module bank_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int SW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall_en = 1'b1;
    logic [1:0] tag_req = '0;
    logic [1:0][SW-1:0] tag_set = '0;
    logic [1:0] data_req = '0;
    logic [1:0][SW-1:0] data_set = '0;

    logic [1:0] tg_a, dg_a, tg_z, dg_z;
    logic xs_a, xs_z;
    logic [3:0] tc_a, dc_a;
    logic [31:0] tc_z, dc_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_gate #(.SET_W(SW), .LANES(2), .TAG_BANKS(4), .TAG_LAT(3),
                .DATA_BANKS(2), .DATA_LAT(2), .CNT_W(4)) uut (
        .clk(clk), .rst(rst), .stall_en(stall_en),
        .tag_req(tag_req), .tag_set(tag_set), .tag_grant(tg_a),
        .data_req(data_req), .data_set(data_set), .data_grant(dg_a),
        .xact_stall(xs_a), .tag_stall_cnt(tc_a), .data_stall_cnt(dc_a));

    bank_gate #(.SET_W(SW), .LANES(2), .TAG_BANKS(1), .TAG_LAT(1),
                .DATA_BANKS(2), .DATA_LAT(0), .CNT_W(32)) uut_z (
        .clk(clk), .rst(rst), .stall_en(stall_en),
        .tag_req(tag_req), .tag_set(tag_set), .tag_grant(tg_z),
        .data_req(data_req), .data_set(data_set), .data_grant(dg_z),
        .xact_stall(xs_z), .tag_stall_cnt(tc_z), .data_stall_cnt(dc_z));

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state: 0 uut tag, 1 uut data, 2 uut_z tag, 3 uut_z data
    int cyc = 0;
    int free_at [4][8];
    int cfg_banks [4] = '{4, 2, 1, 2};
    int cfg_lat [4] = '{3, 2, 1, 0};
    longint cnt [4];
    longint cnt_max [4] = '{15, 15, 64'hFFFF_FFFF, 64'hFFFF_FFFF};

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < 4; a++) begin
            cnt[a] = 0;
            for (int b = 0; b < 8; b++) free_at[a][b] = 0;
        end
    endtask

    task automatic model_array(input int a, input logic se, input logic [1:0] rq,
                               input int s0, input int s1,
                               output logic [1:0] g, output int nref);
        int sets [2];
        int owner [8];
        int newfree [8];
        sets[0] = s0;
        sets[1] = s1;
        g = '0;
        nref = 0;
        for (int b = 0; b < 8; b++) begin
            owner[b] = -1;
            newfree[b] = -1;
        end
        for (int i = 0; i < 2; i++) begin
            if (rq[i]) begin
                int bk;
                bk = sets[i] % cfg_banks[a];
                if (!se || cfg_lat[a] == 0) begin
                    g[i] = 1'b1;
                end else if (cyc < free_at[a][bk]) begin
                    nref++;
                end else if (owner[bk] != -1 && owner[bk] != sets[i]) begin
                    nref++;
                end else begin
                    g[i] = 1'b1;
                    if (owner[bk] == -1) begin
                        owner[bk] = sets[i];
                        newfree[bk] = cyc + cfg_lat[a];
                    end
                end
            end
        end
        for (int b = 0; b < 8; b++) begin
            if (newfree[b] != -1) free_at[a][b] = newfree[b];
        end
    endtask

    task automatic step(input string tg, input logic se,
                        input logic [1:0] tr, input int ts0, input int ts1,
                        input logic [1:0] dr, input int ds0, input int ds1);
        logic [1:0] g [4];
        int nr [4];
        string ctag;
        stall_en = se;
        tag_req = tr;
        tag_set[0] = SW'(ts0);
        tag_set[1] = SW'(ts1);
        data_req = dr;
        data_set[0] = SW'(ds0);
        data_set[1] = SW'(ds1);
        #1;
        ctag = (tg == "R8") ? "R8" : "R7";
        chk(ctag, "tag count", longint'(tc_a), cnt[0]);
        chk(ctag, "data count", longint'(dc_a), cnt[1]);
        chk(ctag, "single-bank tag count", longint'(tc_z), cnt[2]);
        chk("R3", "zero-latency data count", longint'(dc_z), cnt[3]);
        model_array(0, se, tr, ts0, ts1, g[0], nr[0]);
        model_array(1, se, dr, ds0, ds1, g[1], nr[1]);
        model_array(2, se, tr, ts0, ts1, g[2], nr[2]);
        model_array(3, se, dr, ds0, ds1, g[3], nr[3]);
        chk(tg, "tag grant", longint'(tg_a), longint'(g[0]));
        chk(tg, "data grant", longint'(dg_a), longint'(g[1]));
        chk((tg == "R2") ? "R1" : tg, "single-bank tag grant", longint'(tg_z), longint'(g[2]));
        chk("R3", "zero-latency data grant", longint'(dg_z), longint'(g[3]));
        chk("R9", "stall uut", longint'(xs_a), longint'((nr[0] + nr[1]) != 0));
        chk("R9", "stall uut_z", longint'(xs_z), longint'((nr[2] + nr[3]) != 0));
        for (int a = 0; a < 4; a++) begin
            cnt[a] = cnt[a] + nr[a];
            if (cnt[a] > cnt_max[a]) cnt[a] = cnt_max[a];
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc += 2;
        model_reset();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        // R11: reset state, idle lanes are not granted
        chk("R11", "tag count after reset", longint'(tc_a), 0);
        chk("R11", "data count after reset", longint'(dc_a), 0);
        step("R11", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        // R1: sets 5 and 9 share bank 1 of four; data sets 3 and 4 use different banks
        step("R1", 1, 2'b11, 5, 9, 2'b11, 3, 4);
        // R2: bank 1 busy for two more cycles, then free
        step("R2", 1, 2'b01, 1, 0, 2'b01, 1, 0);
        step("R2", 1, 2'b01, 13, 0, 2'b01, 5, 0);
        step("R2", 1, 2'b01, 1, 0, 2'b00, 0, 0);
        step("R2", 1, 2'b00, 0, 0, 2'b00, 0, 0);
        step("R2", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        // R4: same-cycle duplicate granted, different set refused
        step("R4", 1, 2'b11, 2, 2, 2'b11, 6, 6);
        step("R4", 1, 2'b11, 7, 11, 2'b00, 0, 0);
        // R5: same set again while busy
        step("R5", 1, 2'b01, 2, 0, 2'b01, 6, 0);
        step("R5", 1, 2'b00, 0, 0, 2'b00, 0, 0);
        step("R5", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        // R6: checking off, conflicts granted and no bank marked
        step("R6", 0, 2'b11, 0, 4, 2'b11, 0, 2);
        step("R6", 1, 2'b01, 8, 0, 2'b01, 4, 0);
        step("R6", 1, 2'b00, 0, 0, 2'b00, 0, 0);
        step("R6", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        // R10: same set on both arrays at once
        step("R10", 1, 2'b11, 3, 3, 2'b11, 3, 3);
        step("R10", 1, 2'b10, 0, 1, 2'b00, 0, 0);
        step("R10", 1, 2'b00, 0, 0, 2'b00, 0, 0);
        step("R10", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        // R11: reset mid-run clears timers
        step("R11", 1, 2'b01, 5, 0, 2'b01, 1, 0);
        do_reset();
        step("R11", 1, 2'b01, 5, 0, 2'b01, 1, 0);

        // R8: drive conflicts until the 4-bit counters saturate
        for (int k = 0; k < 14; k++) begin
            step("R8", 1, 2'b11, 0, 4, 2'b11, 0, 2);
        end
        step("R8", 1, 2'b00, 0, 0, 2'b00, 0, 0);

        do_reset();
        // R10: random mixed traffic on both arrays
        for (int k = 0; k < 400; k++) begin
            step("R10", ($urandom % 8) != 0,
                 2'($urandom), int'($urandom % 64), int'($urandom % 64),
                 2'($urandom), int'($urandom % 64), int'($urandom % 64));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule